// File: doc/BRIEF.md
# Clock Root Configuration Commit Controller

This block is the register front end of a clock root generator. Software programs a staged set of registers over a simple word-addressed bus: the source select, the half-integer pre-divider, the counter mode, a hardware clock-control bit, and the M, N and D counter values. None of the staged values reach the live clock path when they are written. They sit in shadow registers until software sets the update bit in the command register.

Setting the update bit freezes a snapshot of the shadow set. The snapshot then crosses into the root clock domain through a two-flop synchronised four-phase request and acknowledge, and is loaded into the active register set on a single root clock edge. The update bit reads back as one until the acknowledge has completed its full round trip. Software polls it to learn when the new setting is live. The command register also reports whether the root clock output is stopped, synchronised into the bus domain.

Two commits issued back to back are the normal way to switch safely. The first moves the root onto a safe source. The second then applies the new dividers together with the real source.

Top module: `clk_root_commit`

## Requirements
- R1: After reset the active outputs are all zero (source 0, pre-divider 0 meaning bypass, counter mode 0, hardware control 0, M/N/D 0), and the command and configuration registers read zero.
- R2: Shadow registers read back what was written. In the configuration word (address 1) the pre-divider is at bits [DIV_W-1:0], the source at [8 +: SRC_W], the mode at [13:12] and hardware control at bit 20. M, N and D (addresses 2, 3, 4) keep only their low CNT_W bits, and the upper bits read 0.
- R3: Writing shadow registers leaves every active output unchanged until a commit.
- R4: Writing the command register (address 0) with bit 0 set, while no commit is pending, makes bit 0 read 1 on the next read.
- R5: A commit loads every staged field into the active outputs on one root clock edge. Bit 0 of the command register returns to 0 only after that load, and within 40 bus clock cycles of the command write.
- R6: Bit 31 of the command register mirrors the root-off input (1 = root stopped), delayed by a two-flop synchroniser.
- R7: When only the source field is changed before a commit, the committed pre-divider, mode and counter values stay the same.
- R8: Shadow writes made while a commit is pending are left out of that commit and are applied by the following one.
- R9: Two commits issued one right after the other both complete, and their settings appear on the active outputs in issue order.
- R10: Writing the command register with bit 0 clear has no effect on the update bit or on the active outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, bus domain |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| root_off_i | input | 1 | Root clock stopped indication, asynchronous |
| root_clk | input | 1 | Root (output) clock |
| root_rst_n | input | 1 | Active-low reset, root domain |
| act_src | output | SRC_W | Active source select |
| act_div | output | DIV_W | Active pre-divider code |
| act_mode | output | 2 | Active counter mode |
| act_hwc | output | 1 | Active hardware clock-control bit |
| act_m | output | CNT_W | Active M value |
| act_n | output | CNT_W | Active N value |
| act_d | output | CNT_W | Active D value |

## Verification
Register readback is combinational, so the bench samples it late in the access cycle. The root-off bit is due two bus edges after its input changes, and the bench waits four before reading it. The active outputs change about three root clock edges after the command write, and the update bit clears a few bus cycles after that. The bench therefore compares the active outputs only after polling has seen the update bit clear, and it counts the polls against the 40-cycle bound. A scoreboard monitor, clocked on the root clock's falling edge, pairs every change of the active bundle with the next expected configuration in issue order.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
   localparam int unsigned BUS_AW = 3;
   localparam int unsigned BUS_DW = 32;
   localparam int unsigned MODE_W = 2;

   localparam logic [BUS_AW-1:0] ADR_CMD = 3'd0;
   localparam logic [BUS_AW-1:0] ADR_CFG = 3'd1;
   localparam logic [BUS_AW-1:0] ADR_M   = 3'd2;
   localparam logic [BUS_AW-1:0] ADR_N   = 3'd3;
   localparam logic [BUS_AW-1:0] ADR_D   = 3'd4;

   localparam int unsigned CMD_UPD_BIT  = 0;
   localparam int unsigned CMD_OFF_BIT  = 31;
   localparam int unsigned CFG_DIV_LSB  = 0;
   localparam int unsigned CFG_SRC_LSB  = 8;
   localparam int unsigned CFG_MODE_LSB = 12;
   localparam int unsigned CFG_HWC_BIT  = 20;

   typedef enum logic [1:0] {
      HS_IDLE  = 2'd0,
      HS_RAISE = 2'd1,
      HS_DROP  = 2'd2
   } hs_state_e;
endpackage

// File: rtl/ccr_sync2.sv
module ccr_sync2 (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic stage1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= 1'b0;
         q      <= 1'b0;
      end else begin
         stage1 <= d;
         q      <= stage1;
      end
   end
endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
   import ccr_pkg::*;
#(
   parameter int unsigned SRC_W   = 3,
   parameter int unsigned DIV_W   = 5,
   parameter int unsigned CNT_W   = 8,
   parameter bit          HAS_MND = 1'b1,
   parameter int unsigned SNAP_W  = SRC_W + DIV_W + MODE_W + 1 + 3 * CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic              busy_i,
   input  logic              root_off_i,
   output logic              commit_o,
   output logic [SNAP_W-1:0] snap_o
);
   logic [SRC_W-1:0]  sh_src;
   logic [DIV_W-1:0]  sh_div;
   logic [MODE_W-1:0] sh_mode;
   logic              sh_hwc;
   logic [CNT_W-1:0]  sh_m, sh_n, sh_d;
   logic              wr;
   wire               unused_wdata = ^bus_wdata;

   assign wr = bus_en & bus_we;

   always_comb
      commit_o = wr && (bus_addr == ADR_CMD) && bus_wdata[CMD_UPD_BIT] && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_src  <= '0;
         sh_div  <= '0;
         sh_mode <= '0;
         sh_hwc  <= 1'b0;
      end else if (wr && bus_addr == ADR_CFG) begin
         sh_div  <= bus_wdata[CFG_DIV_LSB +: DIV_W];
         sh_src  <= bus_wdata[CFG_SRC_LSB +: SRC_W];
         sh_mode <= bus_wdata[CFG_MODE_LSB +: MODE_W];
         sh_hwc  <= bus_wdata[CFG_HWC_BIT];
      end
   end

   generate
      if (HAS_MND) begin : g_mnd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_m <= '0;
               sh_n <= '0;
               sh_d <= '0;
            end else if (wr) begin
               if (bus_addr == ADR_M) sh_m <= bus_wdata[CNT_W-1:0];
               if (bus_addr == ADR_N) sh_n <= bus_wdata[CNT_W-1:0];
               if (bus_addr == ADR_D) sh_d <= bus_wdata[CNT_W-1:0];
            end
         end
      end else begin : g_no_mnd
         assign sh_m = '0;
         assign sh_n = '0;
         assign sh_d = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        snap_o <= '0;
      else if (commit_o) snap_o <= {sh_src, sh_div, sh_mode, sh_hwc, sh_m, sh_n, sh_d};
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_we) begin
         case (bus_addr)
            ADR_CMD: begin
               bus_rdata[CMD_UPD_BIT] = busy_i;
               bus_rdata[CMD_OFF_BIT] = root_off_i;
            end
            ADR_CFG: begin
               bus_rdata[CFG_DIV_LSB +: DIV_W]   = sh_div;
               bus_rdata[CFG_SRC_LSB +: SRC_W]   = sh_src;
               bus_rdata[CFG_MODE_LSB +: MODE_W] = sh_mode;
               bus_rdata[CFG_HWC_BIT]            = sh_hwc;
            end
            ADR_M:   bus_rdata[CNT_W-1:0] = sh_m;
            ADR_N:   bus_rdata[CNT_W-1:0] = sh_n;
            ADR_D:   bus_rdata[CNT_W-1:0] = sh_d;
            default: bus_rdata = '0;
         endcase
      end
   end

   // R8
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && $past(busy_i)) |-> $stable(snap_o));
endmodule

// File: rtl/ccr_commit_fsm.sv
module ccr_commit_fsm
   import ccr_pkg::*;
#(
   parameter int unsigned MAX_WAIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic ack_s_i,
   output logic req_o,
   output logic busy_o
);
   localparam int unsigned CW = $clog2(MAX_WAIT + 1);

   hs_state_e       state;
   logic [CW-1:0]   wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= HS_IDLE;
         req_o <= 1'b0;
      end else begin
         case (state)
            HS_IDLE: if (start_i) begin
               state <= HS_RAISE;
               req_o <= 1'b1;
            end
            HS_RAISE: if (ack_s_i) begin
               state <= HS_DROP;
               req_o <= 1'b0;
            end
            HS_DROP: if (!ack_s_i) state <= HS_IDLE;
            default: begin
               state <= HS_IDLE;
               req_o <= 1'b0;
            end
         endcase
      end
   end

   assign busy_o = (state != HS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              wait_cnt <= '0;
      else if (!busy_o)                        wait_cnt <= '0;
      else if (wait_cnt != CW'(MAX_WAIT))      wait_cnt <= wait_cnt + CW'(1);
   end

   // R5
   commit_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (wait_cnt < CW'(MAX_WAIT)));

   // R5
   req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_o) |-> $past(ack_s_i));
endmodule

// File: rtl/ccr_active.sv
module ccr_active #(
   parameter int unsigned SNAP_W = 35
) (
   input  logic              root_clk,
   input  logic              root_rst_n,
   input  logic              req_i,
   input  logic [SNAP_W-1:0] snap_i,
   output logic              ack_o,
   output logic [SNAP_W-1:0] act_o
);
   logic req_s;

   ccr_sync2 u_req_sync (
      .clk   (root_clk),
      .rst_n (root_rst_n),
      .d     (req_i),
      .q     (req_s)
   );

   always_ff @(posedge root_clk or negedge root_rst_n) begin
      if (!root_rst_n) begin
         act_o <= '0;
         ack_o <= 1'b0;
      end else if (req_s && !ack_o) begin
         act_o <= snap_i;
         ack_o <= 1'b1;
      end else if (!req_s) begin
         ack_o <= 1'b0;
      end
   end

   // R3
   active_on_ack_chk: assert property (@(posedge root_clk) disable iff (!root_rst_n)
      (act_o != $past(act_o)) |-> $rose(ack_o));

   // R5
   ack_needs_req_chk: assert property (@(posedge root_clk) disable iff (!root_rst_n)
      $rose(ack_o) |-> $past(req_s));
endmodule

// File: rtl/clk_root_commit.sv
module clk_root_commit
   import ccr_pkg::*;
#(
   parameter int unsigned SRC_W    = 3,
   parameter int unsigned DIV_W    = 5,
   parameter int unsigned CNT_W    = 8,
   parameter bit          HAS_MND  = 1'b1,
   parameter int unsigned MAX_WAIT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [2:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              root_off_i,
   input  logic              root_clk,
   input  logic              root_rst_n,
   output logic [SRC_W-1:0]  act_src,
   output logic [DIV_W-1:0]  act_div,
   output logic [1:0]        act_mode,
   output logic              act_hwc,
   output logic [CNT_W-1:0]  act_m,
   output logic [CNT_W-1:0]  act_n,
   output logic [CNT_W-1:0]  act_d
);
   localparam int unsigned SNAP_W = SRC_W + DIV_W + MODE_W + 1 + 3 * CNT_W;

   generate
      if (SRC_W < 1 || SRC_W > 4) begin : g_bad_src
         $error("SRC_W must lie in 1..4");
      end
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("DIV_W must lie in 1..8");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 1..16");
      end
      if (MAX_WAIT < 16) begin : g_bad_wait
         $error("MAX_WAIT must be at least 16");
      end
   endgenerate

   logic              commit, busy, req, ack, ack_s, off_s;
   logic [SNAP_W-1:0] snap, act_bus;

   ccr_sync2 u_off_sync (.clk(clk), .rst_n(rst_n), .d(root_off_i), .q(off_s));
   ccr_sync2 u_ack_sync (.clk(clk), .rst_n(rst_n), .d(ack),        .q(ack_s));

   ccr_regfile #(
      .SRC_W(SRC_W), .DIV_W(DIV_W), .CNT_W(CNT_W), .HAS_MND(HAS_MND), .SNAP_W(SNAP_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_en     (bus_en),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .busy_i     (busy),
      .root_off_i (off_s),
      .commit_o   (commit),
      .snap_o     (snap)
   );

   ccr_commit_fsm #(.MAX_WAIT(MAX_WAIT)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (commit),
      .ack_s_i (ack_s),
      .req_o   (req),
      .busy_o  (busy)
   );

   ccr_active #(.SNAP_W(SNAP_W)) u_act (
      .root_clk   (root_clk),
      .root_rst_n (root_rst_n),
      .req_i      (req),
      .snap_i     (snap),
      .ack_o      (ack),
      .act_o      (act_bus)
   );

   assign {act_src, act_div, act_mode, act_hwc, act_m, act_n, act_d} = act_bus;
endmodule

// File: tb/clk_root_commit_test.sv
module clk_root_commit_test;
   localparam int VW = 35;

   logic        clk = 1'b0, rst_n = 1'b0, root_clk = 1'b0, root_rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0, root_off_i = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [2:0]  act_src;
   logic [4:0]  act_div;
   logic [1:0]  act_mode;
   logic        act_hwc;
   logic [7:0]  act_m, act_n, act_d;

   int n_chk = 0, n_err = 0;
   logic [VW-1:0] exp_q[$];
   bit finished = 0;

   always #5 clk = ~clk;
   always #7 root_clk = ~root_clk;

   clk_root_commit uut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .root_off_i(root_off_i), .root_clk(root_clk), .root_rst_n(root_rst_n),
      .act_src(act_src), .act_div(act_div), .act_mode(act_mode), .act_hwc(act_hwc),
      .act_m(act_m), .act_n(act_n), .act_d(act_d)
   );

   function automatic logic [VW-1:0] pk(input int s, dv, md, hw, m, n, d);
      pk = {3'(s), 5'(dv), 2'(md), 1'(hw), 8'(m), 8'(n), 8'(d)};
   endfunction

   function automatic logic [31:0] cfgw(input int s, dv, md, hw);
      cfgw = 32'(dv) | (32'(s) << 8) | (32'(md) << 12) | (32'(hw) << 20);
   endfunction

   function automatic logic [VW-1:0] act_now();
      act_now = {act_src, act_div, act_mode, act_hwc, act_m, act_n, act_d};
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #4;
      d = bus_rdata;
      bus_en = 1'b0;
   endtask

   task automatic start_commit(input logic [VW-1:0] e, input bit push);
      if (push) exp_q.push_back(e);
      wr(3'd0, 32'h1);
   endtask

   task automatic wait_done(input string tag);
      logic [31:0] v;
      int polls = 0;
      v = 32'h1;
      while (v[0] && polls < 60) begin
         rd(3'd0, v);
         polls++;
      end
      chk({tag, " update clears within 40 cycles"}, 64'(polls <= 40), 64'd1);
   endtask

   task automatic commit(input logic [VW-1:0] e, input string tag);
      start_commit(e, 1'b1);
      wait_done(tag);
      repeat (3) @(negedge clk);
      chk({tag, " active bundle"}, 64'(act_now()), 64'(e));
   endtask

   // scoreboard monitor: each change of the active bundle pops the next expected item
   initial begin
      logic [VW-1:0] prev, cur, e;
      prev = '0;
      forever begin
         @(negedge root_clk);
         if (root_rst_n) begin
            cur = act_now();
            if (cur !== prev) begin
               if (exp_q.size() == 0) begin
                  chk("R5 unexpected active change", 64'(cur), 64'(prev));
               end else begin
                  e = exp_q.pop_front();
                  chk("R9 monitor order", 64'(cur), 64'(e));
               end
               prev = cur;
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [VW-1:0] cur_cfg;
      repeat (5) @(negedge clk);
      rst_n = 1'b1; root_rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      chk("R1 active after reset", 64'(act_now()), 64'd0);
      rd(3'd0, v); chk("R1 command reg", 64'(v), 64'd0);
      rd(3'd1, v); chk("R1 config reg", 64'(v), 64'd0);

      // R6 root-off status
      root_off_i = 1'b1; repeat (4) @(negedge clk);
      rd(3'd0, v); chk("R6 root off set", 64'(v[31]), 64'd1);
      root_off_i = 1'b0; repeat (4) @(negedge clk);
      rd(3'd0, v); chk("R6 root off clear", 64'(v[31]), 64'd0);

      // R2 staging and readback
      wr(3'd1, cfgw(2, 3, 2, 1));
      wr(3'd2, 32'h0000_0123);
      wr(3'd3, 32'hFFFF_FF5A);
      wr(3'd4, 32'h0000_00C3);
      rd(3'd2, v); chk("R2 M masked", 64'(v), 64'h23);
      rd(3'd3, v); chk("R2 N masked", 64'(v), 64'h5A);
      rd(3'd1, v); chk("R2 config fields", 64'(v), 64'(cfgw(2, 3, 2, 1)));

      // R3 nothing live before commit
      repeat (30) @(negedge clk);
      chk("R3 active untouched", 64'(act_now()), 64'd0);

      // R4 / R5 first commit
      cur_cfg = pk(2, 3, 2, 1, 'h23, 'h5A, 'hC3);
      start_commit(cur_cfg, 1'b1);
      rd(3'd0, v); chk("R4 update reads set", 64'(v[0]), 64'd1);
      wait_done("R5");
      repeat (3) @(negedge clk);
      chk("R5 all fields loaded", 64'(act_now()), 64'(cur_cfg));

      // R7 source-only change
      rd(3'd1, v);
      v = (v & ~(32'h7 << 8)) | (32'h5 << 8);
      wr(3'd1, v);
      cur_cfg = pk(5, 3, 2, 1, 'h23, 'h5A, 'hC3);
      commit(cur_cfg, "R7");
      chk("R7 divider kept", 64'(act_div), 64'd3);
      chk("R7 mode kept", 64'(act_mode), 64'd2);

      // R10 write with bit 0 clear
      wr(3'd0, 32'h0);
      rd(3'd0, v); chk("R10 update stays clear", 64'(v[0]), 64'd0);
      repeat (30) @(negedge clk);
      chk("R10 active unchanged", 64'(act_now()), 64'(cur_cfg));

      // R8 write during pending commit
      wr(3'd2, 32'h11);
      cur_cfg = pk(5, 3, 2, 1, 'h11, 'h5A, 'hC3);
      start_commit(cur_cfg, 1'b1);
      wr(3'd2, 32'h77);
      wait_done("R8");
      repeat (3) @(negedge clk);
      chk("R8 in-flight excludes late write", 64'(act_m), 64'h11);
      rd(3'd2, v); chk("R8 late write staged", 64'(v), 64'h77);
      cur_cfg = pk(5, 3, 2, 1, 'h77, 'h5A, 'hC3);
      commit(cur_cfg, "R8 next");

      // R9 safe switch: two back-to-back commits
      wr(3'd1, cfgw(0, 3, 2, 1));
      commit(pk(0, 3, 2, 1, 'h77, 'h5A, 'hC3), "R9 safe");
      wr(3'd1, cfgw(6, 9, 0, 0));
      wr(3'd2, 32'h04);
      commit(pk(6, 9, 0, 0, 'h04, 'h5A, 'hC3), "R9 final");

      repeat (10) @(negedge clk);
      chk("R9 all commits observed", 64'(exp_q.size()), 64'd0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule